// File: doc/BRIEF.md
# Subtractive GCD Engine

This block computes the greatest common divisor of two unsigned operands. It uses only subtraction and does one compare-and-subtract step per clock. It has no divider and no modulus, so the datapath is two registers, a magnitude comparator and a subtractor. The engine suits places where area matters more than latency, and where a few hundred cycles per result is acceptable.

A one-cycle `start` pulse in the idle state captures both operands. The engine then iterates in its calculation state. While the second register is nonzero, each step takes the smaller register from the larger one. It stops as soon as either register is zero. A zero first register yields the second register's value, and a zero second register yields the first register's value. The result appears for exactly one cycle, with `done` high, and the engine then returns to idle. Between results, `result` reads zero. Reset is synchronous and active high. It returns the controller to idle and clears every register.

Top module: `gcd_engine`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `done` is 0, `result` is 0 and the engine is idle.
- R2: The operands are sampled only at the edge where idle meets `start` high. Later changes to `a_in`/`b_in` do not alter the running computation.
- R3: If the captured first operand is zero, `result` equals the captured second operand. Both zero gives 0.
- R4: If the captured second operand is zero and the first is not, `result` equals the captured first operand.
- R5: For any operand pair, `result` equals the greatest common divisor, and the remaining register sum strictly decreases on every subtract step.
- R6: Let S be the number of subtract steps. S is zero when the first operand is zero. Otherwise, while the second value is nonzero, the larger value loses the smaller, and when the two are equal the second becomes zero. `done` rises S+1 clock edges after the capturing edge.
- R7: `done` is high for exactly one cycle per computation, and `result` is 0 whenever `done` is 0.
- R8: `start` pulses that arrive during the calculation or result cycle are ignored. They start no new computation and do not change the running one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all registers rise-edge triggered |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to capture operands and begin |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| done | output | 1 | High for the single result cycle |
| result | output | WIDTH | GCD during the result cycle, zero otherwise |

## Verification
Two functions can fall in the same cycle. The first is a new `start` request. The second is either the iteration still in progress or the single-cycle result presentation. The bench provokes this by pulsing `start` with fresh operands partway through a calculation, and again on the very cycle `done` is high. It then judges the outcome by checking three things: the original operands' GCD arrives at the predicted latency, `done` is seen only once, and no second result follows within the next few cycles. A second collision is the operand change just after the capture edge. It is judged the same way, by the final result.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CALC   = 2'd1,
    ST_FINISH = 2'd2
  } gcd_state_e;

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic zero_a_i,
  input  logic zero_b_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o
);

  gcd_state_e state_q, state_d;

  always_comb begin
    load_o   = (state_q == ST_IDLE) && start_i;
    finish_o = (state_q == ST_CALC) && (zero_a_i || zero_b_i);
    step_o   = (state_q == ST_CALC) && !zero_a_i && !zero_b_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_CALC;
      ST_CALC:   if (zero_a_i || zero_b_i) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> state_q == ST_IDLE); // R1

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALC && !zero_a_i && !zero_b_i) |=> state_q == ST_CALC); // R8

  AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FINISH) |=> state_q == ST_IDLE); // R8

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_o, step_o, finish_o})); // R6

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] ra_o,
  output logic [WIDTH-1:0] rb_o,
  output logic             zero_a_o,
  output logic             zero_b_o
);

  localparam int SUMW = WIDTH + 1;

  logic [WIDTH-1:0] ra_q, rb_q;
  logic             a_gt_b;
  logic [WIDTH-1:0] diff;
  logic [SUMW-1:0]  sum_w;

  always_comb begin
    a_gt_b = ra_q > rb_q;
    diff   = a_gt_b ? (ra_q - rb_q) : (rb_q - ra_q);
    sum_w  = {1'b0, ra_q} + {1'b0, rb_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q <= '0;
      rb_q <= '0;
    end else if (load_i) begin
      ra_q <= a_i;
      rb_q <= b_i;
    end else if (step_i) begin
      if (a_gt_b) ra_q <= diff;
      else        rb_q <= diff;
    end
  end

  assign ra_o     = ra_q;
  assign rb_o     = rb_q;
  assign zero_a_o = (ra_q == '0);
  assign zero_b_o = (rb_q == '0);

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (ra_q == $past(a_i)) && (rb_q == $past(b_i))); // R2

  AST_SUM_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    step_i |=> sum_w < $past(sum_w)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(ra_q) && $stable(rb_q)); // R2

endmodule

// File: rtl/gcd_result.sv
module gcd_result #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish_i,
  input  logic             pick_b_i,
  input  logic [WIDTH-1:0] ra_i,
  input  logic [WIDTH-1:0] rb_i,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o   <= finish_i;
      result_o <= finish_i ? (pick_b_i ? rb_i : ra_i) : '0;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> result_o == '0); // R7

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  logic             load_w, step_w, finish_w;
  logic             zero_a_w, zero_b_w;
  logic [WIDTH-1:0] ra_w, rb_w;

  gcd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .zero_a_i (zero_a_w),
    .zero_b_i (zero_b_w),
    .load_o   (load_w),
    .step_o   (step_w),
    .finish_o (finish_w)
  );

  gcd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_w),
    .step_i   (step_w),
    .a_i      (a_in),
    .b_i      (b_in),
    .ra_o     (ra_w),
    .rb_o     (rb_w),
    .zero_a_o (zero_a_w),
    .zero_b_o (zero_b_w)
  );

  gcd_result #(.WIDTH(WIDTH)) u_res (
    .clk      (clk),
    .rst      (rst),
    .finish_i (finish_w),
    .pick_b_i (zero_a_w),
    .ra_i     (ra_w),
    .rb_i     (rb_w),
    .done_o   (done),
    .result_o (result)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !done && result == '0); // R1

  AST_ZERO_A_GIVES_B: assert property (@(posedge clk) disable iff (rst)
    (finish_w && zero_a_w) |=> done && result == $past(rb_w)); // R3

  AST_ZERO_B_GIVES_A: assert property (@(posedge clk) disable iff (rst)
    (finish_w && !zero_a_w) |=> done && result == $past(ra_w)); // R4

endmodule

// File: tb/gcd_engine_test.sv
module gcd_engine_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gcd_engine #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .done(done), .result(result)
  );

  function automatic int ref_gcd(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin
      t = x % y; x = y; y = t;
    end
    return x;
  endfunction

  function automatic int ref_steps(input int a, input int b);
    int x = a, y = b, s = 0;
    if (x == 0) return 0;
    while (y != 0) begin
      if (x > y) x = x - y;
      else       y = y - x;
      s++;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 start pulse mid-run, 2 start pulse on result cycle
  task automatic run_case(input int a, input int b, input int mode, input string req);
    int n = 0;
    int lat = ref_steps(a, b) + 1;
    int g = (a == 0) ? b : ((b == 0) ? a : ref_gcd(a, b));
    @(negedge clk);
    a_in = W'(a); b_in = W'(b); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    a_in = W'($urandom); b_in = W'($urandom);  // R2: later operand changes ignored
    while (n < 2000) begin
      @(posedge clk); #1;
      n++;
      start = 1'b0;
      if (done) break;
      if (mode == 1 && n == 1) start = 1'b1;  // R8: collision with calculation
      check(result == '0, "R7 result zero while busy", int'(result), 0);
    end
    check(done == 1'b1, "R6 done seen", int'(done), 1);
    check(n == lat, {req, " R6 latency"}, n, lat);
    check(int'(result) == g, {req, " R5 gcd value"}, int'(result), g);
    if (mode == 2) start = 1'b1;  // R8: collision with result cycle
    @(posedge clk); #1;
    start = 1'b0;
    check(!done && result == '0, "R7 done single cycle", int'(done), 0);
    if (mode != 0) begin
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); #1;
        check(!done, "R8 no restart from ignored start", int'(done), 0);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    check(!done, "R1 done cleared in reset", int'(done), 0);
    check(result == '0, "R1 result cleared in reset", int'(result), 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(posedge clk); #1;
    check(!done, "R1 idle after reset", int'(done), 0);

    run_case(0, 0, 0, "R3 both zero");
    run_case(0, 7, 0, "R3 first zero");
    run_case(0, 255, 0, "R3 first zero max");
    run_case(9, 0, 0, "R4 second zero");
    run_case(12, 12, 0, "R5 equal");
    run_case(255, 1, 0, "R5 long run");
    run_case(1, 255, 0, "R5 long run swapped");
    run_case(48, 18, 1, "R8 mid start");
    run_case(91, 35, 2, "R8 result-cycle start");

    for (int i = 0; i < 150; i++) begin
      run_case(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
               int'($urandom_range(0, 2)), "R5 random");
    end

    // R1: reset in the middle of a calculation
    @(negedge clk); a_in = 8'd200; b_in = 8'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check(!done && result == '0, "R1 reset mid-run", int'(result), 0);
    @(negedge clk); rst = 1'b0;
    repeat (5) @(posedge clk); #1;
    check(!done, "R1 no result after reset abort", int'(done), 0);
    run_case(27, 36, 0, "R1 usable after reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule